// File: doc/BRIEF.md
# Segmented-Pixel Hit Timing Channel

This block is the digital back end of one pixel channel whose sensing area is split into eight collection diodes. Each diode has its own discriminator, and the channel keeps one sticky hit bit per diode. The eight discriminator levels are also merged into one combined level. A single pair of timers runs on that combined level: an 8-bit time of arrival counted in timing-clock bins, and a 5-bit time over threshold that gives an amplitude estimate for time-walk correction. Both timers belong to the same, first, combined hit of the window.

An acquisition window is prepared with a synchronous clear and then opened with the shutter input. While the shutter is high and the gate enable is high, the channel counts and records. When the shutter drops, all results stay frozen for readout. The discriminator inputs are asynchronous and pass through a two-stage synchronizer, which adds two clock cycles to every measured arrival time. When the gate enable is low, no counter or result register changes, so an idle channel does not toggle.

Top module: `pxl_hit_timer`

## Requirements
- R1: While `rst_ni` is low, and after its release, `hit_map_o`, `toa_o`, `tot_o` and `hit_valid_o` are all zero.
- R2: Bit i of `hit_map_o` becomes 1 after a rising edge on `disc_i[i]` during an enabled window. It stays 1 until a clear, and several bits can be set in the same window.
- R3: `toa_o` equals the number of enabled clock cycles from the first enabled cycle of the window up to the first rising edge of the OR of all diodes, plus 2 cycles of synchronizer delay. If an input rises on the same cycle the shutter opens, `toa_o` reads 2. `hit_valid_o` goes to 1 together with the capture.
- R4: `tot_o` equals the number of clock cycles the combined level stays high in its first pulse of the window. It saturates at 31 and does not wrap.
- R5: A later rising edge of the combined level in the same window leaves `toa_o`, `tot_o` and `hit_valid_o` unchanged. It still sets the hit bit of the diode that rose.
- R6: If no combined rising edge arrives before `toa_o` reaches 255, `toa_o` stays at 255 and `hit_valid_o` stays 0 for the rest of the window, even if a hit comes later. Per-diode hit bits are still recorded.
- R7: A diode that is already high when the window opens does not count as a hit until it falls and rises again.
- R8: While `cg_en_i` is low, none of the outputs changes, and edges during that time are not recorded.
- R9: While `shutter_i` is low, none of the outputs changes.
- R10: `clear_i` high at a clock edge sets all four outputs to zero on that edge. It takes priority over shutter and gate enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Timing clock; one cycle is one arrival-time bin |
| rst_ni | input | 1 | Synchronous reset, active low |
| disc_i | input | 8 | Asynchronous discriminator levels, one per diode |
| shutter_i | input | 1 | Acquisition window open when high |
| clear_i | input | 1 | Synchronous clear of all results |
| cg_en_i | input | 1 | Gate enable; low freezes all counting and recording |
| hit_map_o | output | 8 | Sticky per-diode hit bits |
| toa_o | output | 8 | Captured time of arrival |
| tot_o | output | 5 | Captured time over threshold |
| hit_valid_o | output | 1 | A combined hit was timed in this window |

## Verification
The bench checks the exact arrival count, including the synchronizer offset, at zero delay and at non-zero delay. A timer with an off-by-one start or a missing sync stage would read one or two bins off. Overlapping and staggered diode pulses are used to show that the width measures the merged pulse and that a second pulse neither re-arms the timers nor adds to the width. A design that retriggered would overwrite the arrival time or accumulate width. Other tests drive pulses longer than 31 cycles, let the window run out before the first hit, and hold an input high at window open. These would expose wrap-around, a late capture after saturation, and a level mistaken for an edge. Inputs are also pulsed while the gate enable is low and while the shutter is closed, to catch a block that counts or records while it should be frozen.

// File: rtl/pxl_hit_pkg.sv
// Package: shared sizes and the timer phase type of the pixel hit channel.
// Assumes: one channel per instance; sizes are set for an eight-diode cell.
package pxl_hit_pkg;
    localparam int unsigned N_DIODE     = 8;
    localparam int unsigned TOA_W       = 8;
    localparam int unsigned TOT_W       = 5;
    localparam int unsigned SYNC_STAGES = 2;

    // Timer phase: waiting for first combined edge, measuring width, done.
    typedef enum logic [1:0] {
        PH_ARMED = 2'd0,
        PH_WIDTH = 2'd1,
        PH_HELD  = 2'd2
    } timer_phase_e;
endpackage

// File: rtl/pxl_sync.sv
// Module: multi-stage synchronizer for a bus of independent asynchronous bits.
// Assumes: each bit is a slow level (no multi-bit coherence needed);
// STAGES >= 2. Runs every cycle so edge history is never stale.
module pxl_sync #(
    parameter int unsigned WIDTH  = 8,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] stage_q [STAGES];

    // Shift the asynchronous levels through the flop chain.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
        end else begin
            stage_q[0] <= async_i;
            for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
        end
    end

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/pxl_edge_map.sv
// Module: per-diode rising-edge detection, sticky hit bitmap and the
// combined (OR) level and rising edge that drive the channel timers.
// Assumes: inputs already synchronized; edge history updates every cycle,
// so a level present when the window opens is not seen as an edge.
module pxl_edge_map #(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] level_i,
    input  logic             arm_i,
    input  logic             clr_i,
    output logic [WIDTH-1:0] map_o,
    output logic             any_level_o,
    output logic             any_rise_o
);
    logic [WIDTH-1:0] prev_q;
    logic [WIDTH-1:0] map_q;
    logic [WIDTH-1:0] rise;

    assign rise        = level_i & ~prev_q;
    assign any_level_o = |level_i;
    assign any_rise_o  = (|level_i) & ~(|prev_q);

    // Keep one cycle of level history for edge detection.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) prev_q <= '0;
        else         prev_q <= level_i;
    end

    // Accumulate sticky hit bits while the window is enabled.
    always_ff @(posedge clk_i) begin
        if (!rst_ni)     map_q <= '0;
        else if (clr_i)  map_q <= '0;
        else if (arm_i)  map_q <= map_q | rise;
    end

    assign map_o = map_q;
endmodule

// File: rtl/pxl_timer.sv
// Module: arrival-time and width timers for the combined hit level.
// Assumes: rise_i/level_i are synchronous; arm_i is high only in enabled
// window cycles; both counters saturate and stop, so nothing toggles idle.
module pxl_timer
    import pxl_hit_pkg::*;
#(
    parameter int unsigned TOA_BITS = 8,
    parameter int unsigned TOT_BITS = 5
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                arm_i,
    input  logic                clr_i,
    input  logic                rise_i,
    input  logic                level_i,
    output logic [TOA_BITS-1:0] toa_o,
    output logic [TOT_BITS-1:0] tot_o,
    output logic                valid_o
);
    localparam logic [TOA_BITS-1:0] TOA_MAX = {TOA_BITS{1'b1}};
    localparam logic [TOT_BITS-1:0] TOT_MAX = {TOT_BITS{1'b1}};
    localparam logic [TOT_BITS-1:0] TOT_ONE = {{(TOT_BITS-1){1'b0}}, 1'b1};

    timer_phase_e        phase_q;
    logic [TOA_BITS-1:0] toa_q;
    logic [TOT_BITS-1:0] tot_q;

    // Count arrival bins, capture the first edge, then measure its width.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            phase_q <= PH_ARMED;
            toa_q   <= '0;
            tot_q   <= '0;
        end else if (clr_i) begin
            phase_q <= PH_ARMED;
            toa_q   <= '0;
            tot_q   <= '0;
        end else if (arm_i) begin
            unique case (phase_q)
                PH_ARMED: begin
                    if (toa_q != TOA_MAX) begin
                        if (rise_i) begin
                            phase_q <= PH_WIDTH;
                            tot_q   <= TOT_ONE;
                        end else begin
                            toa_q <= toa_q + 1'b1;
                        end
                    end
                end
                PH_WIDTH: begin
                    if (!level_i)             phase_q <= PH_HELD;
                    else if (tot_q != TOT_MAX) tot_q  <= tot_q + 1'b1;
                end
                default: ;
            endcase
        end
    end

    assign toa_o   = toa_q;
    assign tot_o   = tot_q;
    assign valid_o = (phase_q != PH_ARMED);
endmodule

// File: rtl/pxl_hit_timer.sv
// Module: top of one segmented pixel channel. Synchronizes the diode
// discriminators, keeps a sticky per-diode hit map and times the first
// combined hit (arrival and width). Results hold until the next clear.
// Assumes: clk_i is the timing clock; clear_i precedes each window.
module pxl_hit_timer
    import pxl_hit_pkg::*;
(
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [N_DIODE-1:0] disc_i,
    input  logic               shutter_i,
    input  logic               clear_i,
    input  logic               cg_en_i,
    output logic [N_DIODE-1:0] hit_map_o,
    output logic [TOA_W-1:0]   toa_o,
    output logic [TOT_W-1:0]   tot_o,
    output logic               hit_valid_o
);
    logic [N_DIODE-1:0] disc_sync;
    logic               comb_level;
    logic               comb_rise;
    logic               arm;

    // Window cycles: shutter open and gate enabled.
    assign arm = shutter_i & cg_en_i;

    pxl_sync #(
        .WIDTH  (N_DIODE),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i (disc_i),
        .sync_o  (disc_sync)
    );

    pxl_edge_map #(
        .WIDTH (N_DIODE)
    ) u_map (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .level_i     (disc_sync),
        .arm_i       (arm),
        .clr_i       (clear_i),
        .map_o       (hit_map_o),
        .any_level_o (comb_level),
        .any_rise_o  (comb_rise)
    );

    pxl_timer #(
        .TOA_BITS (TOA_W),
        .TOT_BITS (TOT_W)
    ) u_timer (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .arm_i   (arm),
        .clr_i   (clear_i),
        .rise_i  (comb_rise),
        .level_i (comb_level),
        .toa_o   (toa_o),
        .tot_o   (tot_o),
        .valid_o (hit_valid_o)
    );
endmodule

// File: rtl/pxl_hit_timer_chk.sv
// Checker: temporal properties of the pixel hit channel, bound to the top.
module pxl_hit_timer_chk
    import pxl_hit_pkg::*;
(
    input logic               clk_i,
    input logic               rst_ni,
    input logic [N_DIODE-1:0] disc_i,
    input logic               shutter_i,
    input logic               clear_i,
    input logic               cg_en_i,
    input logic [N_DIODE-1:0] hit_map_o,
    input logic [TOA_W-1:0]   toa_o,
    input logic [TOT_W-1:0]   tot_o,
    input logic               hit_valid_o
);
    // R10
    clear_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clear_i |=> (hit_map_o == '0 && toa_o == '0 && tot_o == '0 && !hit_valid_o));

    // R2
    map_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !clear_i |=> (($past(hit_map_o) & ~hit_map_o) == '0));

    // R5
    toa_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (hit_valid_o && !clear_i) |=> (hit_valid_o && $stable(toa_o)));

    // R3
    valid_has_map_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        hit_valid_o |-> (hit_map_o != '0));

    // R4
    tot_monotone_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !clear_i |=> (tot_o >= $past(tot_o)));

    // R8
    gate_freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!cg_en_i && !clear_i) |=> ($stable(hit_map_o) && $stable(toa_o)
                                    && $stable(tot_o) && $stable(hit_valid_o)));

    // R9
    shutter_freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!shutter_i && !clear_i) |=> ($stable(hit_map_o) && $stable(toa_o)
                                      && $stable(tot_o) && $stable(hit_valid_o)));

    // R6
    toa_sat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (toa_o == '1 && !hit_valid_o && !clear_i) |=> (toa_o == '1 && !hit_valid_o));
endmodule

bind pxl_hit_timer pxl_hit_timer_chk u_chk (.*);

// File: tb/pxl_hit_timer_bench.sv
// Bench: directed scenarios for the pixel hit channel; one task per case.
module pxl_hit_timer_bench;
    logic       clk_i = 1'b0;
    logic       rst_ni = 1'b0;
    logic [7:0] disc_i = '0;
    logic       shutter_i = 1'b0;
    logic       clear_i = 1'b0;
    logic       cg_en_i = 1'b1;
    logic [7:0] hit_map_o;
    logic [7:0] toa_o;
    logic [4:0] tot_o;
    logic       hit_valid_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk_i = ~clk_i;

    pxl_hit_timer u_pxl_hit_timer (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .disc_i      (disc_i),
        .shutter_i   (shutter_i),
        .clear_i     (clear_i),
        .cg_en_i     (cg_en_i),
        .hit_map_o   (hit_map_o),
        .toa_o       (toa_o),
        .tot_o       (tot_o),
        .hit_valid_o (hit_valid_o)
    );

    task automatic check_val(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic check_all(input string req, input int m, input int a, input int t, input int v);
        check_val(req, "hit_map", int'(hit_map_o), m);
        check_val(req, "toa", int'(toa_o), a);
        check_val(req, "tot", int'(tot_o), t);
        check_val(req, "valid", int'(hit_valid_o), v);
    endtask

    // Clear with everything low; returns at a negedge with clear released.
    task automatic do_clear();
        @(negedge clk_i);
        disc_i = '0; shutter_i = 1'b0; cg_en_i = 1'b1; clear_i = 1'b1;
        repeat (3) @(negedge clk_i);
        clear_i = 1'b0;
    endtask

    // Raise mask at current negedge, hold for width cycles.
    task automatic pulse(input logic [7:0] mask, input int width);
        disc_i = disc_i | mask;
        repeat (width) @(negedge clk_i);
        disc_i = disc_i & ~mask;
    endtask

    task automatic t_reset();
        @(negedge clk_i);
        check_all("R1", 0, 0, 0, 0);
    endtask

    task automatic t_basic();
        do_clear();
        shutter_i = 1'b1;
        repeat (5) @(posedge clk_i);
        @(negedge clk_i);
        pulse(8'h08, 4);
        repeat (4) @(negedge clk_i);
        check_all("R3", 8'h08, 7, 4, 1);
        // R9: closed shutter freezes everything
        shutter_i = 1'b0;
        pulse(8'h01, 3);
        repeat (4) @(negedge clk_i);
        check_all("R9", 8'h08, 7, 4, 1);
        // R10: clear wipes results
        clear_i = 1'b1;
        @(negedge clk_i);
        clear_i = 1'b0;
        check_all("R10", 0, 0, 0, 0);
    endtask

    task automatic t_staggered();
        do_clear();
        shutter_i = 1'b1;
        pulse(8'h01, 3);
        repeat (4) @(negedge clk_i);
        check_all("R3", 8'h01, 2, 3, 1);
        pulse(8'h20, 2);
        repeat (4) @(negedge clk_i);
        check_all("R5", 8'h21, 2, 3, 1);
    endtask

    task automatic t_overlap();
        do_clear();
        shutter_i = 1'b1;
        repeat (10) @(posedge clk_i);
        @(negedge clk_i);
        disc_i = 8'h02;
        repeat (2) @(negedge clk_i);
        disc_i = 8'h42;
        repeat (4) @(negedge clk_i);
        disc_i = 8'h00;
        repeat (4) @(negedge clk_i);
        check_all("R2", 8'h42, 12, 6, 1);
    endtask

    task automatic t_tot_sat();
        do_clear();
        shutter_i = 1'b1;
        pulse(8'h10, 40);
        repeat (4) @(negedge clk_i);
        check_val("R4", "tot saturated", int'(tot_o), 31);
        check_val("R4", "toa", int'(toa_o), 2);
    endtask

    task automatic t_toa_sat();
        do_clear();
        shutter_i = 1'b1;
        repeat (300) @(negedge clk_i);
        check_all("R6", 0, 255, 0, 0);
        pulse(8'h04, 3);
        repeat (4) @(negedge clk_i);
        check_all("R6", 8'h04, 255, 0, 0);
    endtask

    task automatic t_level_at_open();
        do_clear();
        disc_i = 8'h10;
        repeat (4) @(negedge clk_i);
        shutter_i = 1'b1;
        repeat (5) @(negedge clk_i);
        check_val("R7", "hit_map", int'(hit_map_o), 0);
        check_val("R7", "valid", int'(hit_valid_o), 0);
        disc_i = 8'h00;
        repeat (3) @(negedge clk_i);
        pulse(8'h10, 2);
        repeat (4) @(negedge clk_i);
        check_val("R7", "hit_map after re-rise", int'(hit_map_o), 8'h10);
        check_val("R7", "valid after re-rise", int'(hit_valid_o), 1);
    endtask

    task automatic t_gate();
        do_clear();
        shutter_i = 1'b1;
        repeat (3) @(posedge clk_i);
        @(negedge clk_i);
        cg_en_i = 1'b0;
        pulse(8'h80, 3);
        repeat (5) @(negedge clk_i);
        check_all("R8", 0, 3, 0, 0);
        cg_en_i = 1'b1;
        pulse(8'h80, 2);
        repeat (4) @(negedge clk_i);
        check_all("R8", 8'h80, 5, 2, 1);
    endtask

    task automatic t_shutter_before_hit();
        do_clear();
        shutter_i = 1'b1;
        repeat (4) @(posedge clk_i);
        @(negedge clk_i);
        shutter_i = 1'b0;
        repeat (10) @(negedge clk_i);
        check_all("R9", 0, 4, 0, 0);
    endtask

    initial begin
        repeat (4) @(negedge clk_i);
        rst_ni = 1'b1;
        t_reset();
        t_basic();
        t_staggered();
        t_overlap();
        t_tot_sat();
        t_toa_sat();
        t_level_at_open();
        t_gate();
        t_shutter_before_hit();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk_i);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule